// File: doc/BRIEF.md
# I2C Addressed Memory Transaction Sequencer

This block drives a byte-wise I2C master on behalf of a client that wants whole memory transactions with serial EEPROM-style devices. The client issues one command carrying a direction, a 7-bit device number, a register address of zero to four bytes and a byte count. The sequencer then emits the byte operations (START plus byte, plain byte send, byte receive with a chosen acknowledge, STOP) to the byte engine. Write data is taken from a valid/ready stream and read data is handed out on a second valid/ready stream. A single-cycle completion pulse carries a status code.

A write sends the device byte with the direction bit clear, the address bytes, then the payload. A read with an address first writes the address, then issues a repeated START with the direction bit set and receives the payload. A read without an address starts directly in receive direction. A probe command is a one-byte read with no address whose data is dropped; only the device acknowledge matters. Optionally, address bits above the transmitted address bytes are ORed into the device number through a build-time mask. This serves parts that hide high address bits in the device number.

Before touching the bus the sequencer waits a bounded time for the bus to become free. Every byte operation has its own completion deadline.

Top module: `i2c_mem_seq`

## Requirements
- R1: A write sends START with byte {dev,0}, then the address bytes, then one SEND per payload byte taken from the write stream in arrival order, then STOP.
- R2: A read with a nonzero address length sends START {dev,0}, the address bytes, a second START with {dev,1}, then one RECV per payload byte, then STOP.
- R3: A read with address length 0 sends START {dev,1}, the RECV operations, then STOP.
- R4: Every RECV requests an ACK (ack output 1) except the last of the transaction, which requests a NACK (0). Every transaction that reached the bus ends with exactly one STOP.
- R5: A command with byte count 0, or with an address length above 4, completes with status 1 and issues no bus operation.
- R6: While the bus-busy input is high, the sequencer waits up to IDLE_TMO cycles. If the bus is still busy, it completes with status 4 and issues no bus operation.
- R7: A NACK on any transmitted byte (START or SEND) stops the sequence: only a STOP follows, and the status is 2.
- R8: A byte operation with no completion within BYTE_TMO cycles is abandoned. Only a STOP follows, and the status is 4. A completion in the last cycle of the window still counts.
- R9: A probe issues START {dev,1}, one RECV with NACK, and STOP. It puts nothing on the read stream and returns status 0 if the device byte is acknowledged, 2 if not.
- R10: With folding enabled and address length n>0, the device number sent is dev | ((addr >> 8n) & FOLD_MASK). With folding off or n=0 it is dev.
- R11: Status codes are 0 ok, 1 error, 2 NACK, 4 timeout. They are valid during a one-cycle done pulse, and commands are accepted only while idle.
- R12: Address bytes go out most significant first, taken from the low n bytes of the 32-bit address.
- R13: Read data is held stable on the read stream until accepted. Stalling the consumer neither loses nor reorders bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle (idle) |
| cmd_read | input | 1 | 1 read, 0 write |
| cmd_probe | input | 1 | Probe command (overrides read, length, address length) |
| cmd_fold | input | 1 | Enable folding of high address bits into the device number |
| cmd_dev | input | 7 | 7-bit device number |
| cmd_addr | input | 32 | Register address |
| cmd_alen | input | 3 | Address length in bytes |
| cmd_len | input | LEN_W | Payload byte count |
| bus_busy | input | 1 | Bus currently occupied |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| bm_req | output | 1 | One-cycle byte operation request |
| bm_op | output | 2 | 0 START+byte, 1 SEND, 2 RECV, 3 STOP |
| bm_byte | output | 8 | Byte to transmit |
| bm_ack | output | 1 | For RECV: 1 send ACK, 0 send NACK |
| bm_done | input | 1 | Byte operation finished |
| bm_nack | input | 1 | Transmitted byte was not acknowledged (with bm_done) |
| bm_rdata | input | 8 | Received byte (with bm_done) |
| done | output | 1 | Transaction complete pulse |
| status | output | 3 | Result code, valid with done |

## Verification
A byte completion and the expiry of its deadline can land in the same cycle. The design must then treat the byte as finished. The bench's byte-engine model delays one chosen completion to exactly BYTE_TMO cycles after the request, and to one cycle more in a second run. The first run must yield the full operation list and status 0. The second must yield STOP straight after the late operation and status 4. A bounded busy period and an acknowledge failure on the device byte are exercised the same way, by their operation lists and status codes.

// File: rtl/i2cseq_pkg.sv
// Shared encodings for the memory transaction sequencer.
// Assumes the byte engine decodes the 2-bit operation code below.
package i2cseq_pkg;
    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_SEND  = 2'd1,
        BOP_RECV  = 2'd2,
        BOP_STOP  = 2'd3
    } bop_e;

    typedef enum logic [2:0] {
        PH_DEVW, PH_ADDR, PH_DEVR, PH_WDATA, PH_RDATA, PH_STOP
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT_BUS, S_ISSUE, S_WAIT_BYTE, S_RDOUT, S_FINISH
    } state_e;

    localparam logic [2:0] RES_OK   = 3'd0;
    localparam logic [2:0] RES_ERR  = 3'd1;
    localparam logic [2:0] RES_NACK = 3'd2;
    localparam logic [2:0] RES_TMO  = 3'd4;
endpackage

// File: rtl/i2cseq_timer.sv
// Deadline counter: counts cycles while run is high and flags expiry
// on the LIMIT-th counted cycle. Assumes LIMIT >= 1; clr restarts it.
module i2cseq_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Advance the count during a wait, restart it outside one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R8
endmodule

// File: rtl/i2cseq_fold.sv
// Folds address bits that lie above the transmitted address bytes into
// the device number through MASK. Assumes alen is the effective length.
module i2cseq_fold #(
    parameter logic [6:0] MASK = 7'h07
) (
    input  logic        en,
    input  logic [6:0]  dev,
    input  logic [31:0] addr,
    input  logic [2:0]  alen,
    output logic [6:0]  dev_out
);
    logic [39:0] upper;

    // Shift away the bytes that go on the wire and mask what remains.
    always_comb begin
        upper = {8'h00, addr} >> {alen, 3'b000};
        if (en && (alen != 3'd0))
            dev_out = dev | (upper[6:0] & MASK);
        else
            dev_out = dev;
    end
endmodule

// File: rtl/i2c_mem_seq.sv
// Command-level sequencer: turns one read/write/probe command into
// byte operations for a byte-wise I2C engine. Assumes the engine answers
// each one-cycle request with one bm_done pulse, and that bus arbitration
// is not this block's concern.
module i2c_mem_seq
    import i2cseq_pkg::*;
#(
    parameter int         LEN_W     = 16,
    parameter int         IDLE_TMO  = 1000,
    parameter int         BYTE_TMO  = 1000,
    parameter logic [6:0] FOLD_MASK = 7'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_read,
    input  logic             cmd_probe,
    input  logic             cmd_fold,
    input  logic [6:0]       cmd_dev,
    input  logic [31:0]      cmd_addr,
    input  logic [2:0]       cmd_alen,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             bus_busy,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             bm_req,
    output logic [1:0]       bm_op,
    output logic [7:0]       bm_byte,
    output logic             bm_ack,
    input  logic             bm_done,
    input  logic             bm_nack,
    input  logic [7:0]       bm_rdata,
    output logic             done,
    output logic [2:0]       status
);
    localparam logic [2:0]       MAX_ALEN = 3'd4;
    localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

    state_e           state;
    phase_e           phase;
    logic [2:0]       res_q;
    logic             is_rd, probe_q;
    logic [6:0]       dev_q, dev_fold;
    logic [31:0]      addr_q;
    logic [2:0]       arem, arem_m1;
    logic [LEN_W-1:0] drem;
    logic [7:0]       rbuf, abyte;
    logic [2:0]       eff_alen;
    logic [LEN_W-1:0] eff_len;
    logic             bus_exp, byte_exp;
    bop_e             op_c;

    // A probe is forced to a one-byte read with no address bytes.
    assign eff_alen = cmd_probe ? 3'd0 : cmd_alen;
    assign eff_len  = cmd_probe ? ONE  : cmd_len;

    i2cseq_fold #(.MASK(FOLD_MASK)) u_fold (
        .en(cmd_fold), .dev(cmd_dev), .addr(cmd_addr),
        .alen(eff_alen), .dev_out(dev_fold)
    );

    i2cseq_timer #(.LIMIT(IDLE_TMO)) u_bus_tmr (
        .clk(clk), .rst_n(rst_n), .clr(state != S_WAIT_BUS),
        .run(state == S_WAIT_BUS), .expired(bus_exp)
    );

    i2cseq_timer #(.LIMIT(BYTE_TMO)) u_byte_tmr (
        .clk(clk), .rst_n(rst_n), .clr(state != S_WAIT_BYTE),
        .run(state == S_WAIT_BYTE), .expired(byte_exp)
    );

    // Main sequencing: command capture, bus wait, byte steps, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            phase   <= PH_DEVW;
            res_q   <= RES_OK;
            is_rd   <= 1'b0;
            probe_q <= 1'b0;
            dev_q   <= '0;
            addr_q  <= '0;
            arem    <= '0;
            drem    <= '0;
            rbuf    <= '0;
        end else begin
            case (state)
                S_IDLE: if (cmd_valid) begin
                    is_rd   <= cmd_read | cmd_probe;
                    probe_q <= cmd_probe;
                    dev_q   <= dev_fold;
                    addr_q  <= cmd_addr;
                    arem    <= eff_alen;
                    drem    <= eff_len;
                    res_q   <= RES_OK;
                    if (eff_len == '0 || eff_alen > MAX_ALEN) begin
                        res_q <= RES_ERR;
                        state <= S_FINISH;
                    end else begin
                        state <= S_WAIT_BUS;
                    end
                end
                S_WAIT_BUS: begin
                    if (!bus_busy) begin
                        state <= S_ISSUE;
                        phase <= (is_rd && arem == 3'd0) ? PH_DEVR : PH_DEVW;
                    end else if (bus_exp) begin
                        res_q <= RES_TMO;
                        state <= S_FINISH;
                    end
                end
                S_ISSUE: if (bm_req) state <= S_WAIT_BYTE;
                S_WAIT_BYTE: begin
                    if (bm_done) begin
                        if (phase == PH_STOP) begin
                            state <= S_FINISH;
                        end else if (phase != PH_RDATA && bm_nack) begin
                            res_q <= RES_NACK;
                            phase <= PH_STOP;
                            state <= S_ISSUE;
                        end else begin
                            state <= S_ISSUE;
                            case (phase)
                                PH_DEVW: phase <= (arem != 3'd0) ? PH_ADDR : PH_WDATA;
                                PH_ADDR: begin
                                    arem <= arem_m1;
                                    if (arem == 3'd1) phase <= is_rd ? PH_DEVR : PH_WDATA;
                                end
                                PH_DEVR: phase <= PH_RDATA;
                                PH_WDATA: begin
                                    drem <= drem - ONE;
                                    if (drem == ONE) phase <= PH_STOP;
                                end
                                PH_RDATA: begin
                                    drem <= drem - ONE;
                                    rbuf <= bm_rdata;
                                    if (drem == ONE) phase <= PH_STOP;
                                    if (!probe_q) state <= S_RDOUT;
                                end
                                default: phase <= PH_STOP;
                            endcase
                        end
                    end else if (byte_exp) begin
                        res_q <= RES_TMO;
                        if (phase == PH_STOP) begin
                            state <= S_FINISH;
                        end else begin
                            phase <= PH_STOP;
                            state <= S_ISSUE;
                        end
                    end
                end
                S_RDOUT:  if (rd_ready) state <= S_ISSUE;
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Pick the address byte still to send, most significant first.
    assign arem_m1 = arem - 3'd1;
    assign abyte   = 8'(addr_q >> {arem_m1, 3'b000});

    // Translate the current phase into one byte-engine operation.
    always_comb begin
        bm_byte = 8'h00;
        bm_ack  = 1'b0;
        case (phase)
            PH_DEVW:  begin op_c = BOP_START; bm_byte = {dev_q, 1'b0}; end
            PH_DEVR:  begin op_c = BOP_START; bm_byte = {dev_q, 1'b1}; end
            PH_ADDR:  begin op_c = BOP_SEND;  bm_byte = abyte; end
            PH_WDATA: begin op_c = BOP_SEND;  bm_byte = wr_data; end
            PH_RDATA: begin op_c = BOP_RECV;  bm_ack = (drem != ONE); end
            default:  op_c = BOP_STOP;
        endcase
    end

    assign bm_op     = op_c;
    assign bm_req    = (state == S_ISSUE) && !(phase == PH_WDATA && !wr_valid);
    assign wr_ready  = (state == S_ISSUE) && (phase == PH_WDATA);
    assign rd_valid  = (state == S_RDOUT);
    assign rd_data   = rbuf;
    assign cmd_ready = (state == S_IDLE);
    assign done      = (state == S_FINISH);
    assign status    = res_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == RES_OK || status == RES_ERR ||
                  status == RES_NACK || status == RES_TMO)); // R11
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req |=> !bm_req); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R13
    AST_BAD_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !cmd_probe && cmd_len == '0 |=> !bm_req && done); // R5
endmodule

// File: tb/i2c_mem_seq_bench.sv
`timescale 1ns/100ps
module i2c_mem_seq_bench;
    localparam int LW = 8;
    localparam int ITMO = 16;
    localparam int BTMO = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, cmd_read = 0, cmd_probe = 0, cmd_fold = 0;
    logic [6:0] cmd_dev = 0;
    logic [31:0] cmd_addr = 0;
    logic [2:0] cmd_alen = 0;
    logic [LW-1:0] cmd_len = 0;
    logic bus_busy = 0, wr_valid = 1, rd_ready = 1;
    logic [7:0] wr_data;
    logic bm_done = 0, bm_nack = 0;
    logic [7:0] bm_rdata = 0;
    logic cmd_ready, wr_ready, rd_valid, bm_req, bm_ack, done;
    logic [7:0] rd_data, bm_byte;
    logic [1:0] bm_op;
    logic [2:0] status;

    always #2.5 clk = ~clk;

    i2c_mem_seq #(.LEN_W(LW), .IDLE_TMO(ITMO), .BYTE_TMO(BTMO), .FOLD_MASK(7'h07)) u_i2c_mem_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_read(cmd_read), .cmd_probe(cmd_probe), .cmd_fold(cmd_fold),
        .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_alen(cmd_alen), .cmd_len(cmd_len),
        .bus_busy(bus_busy), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .bm_req(bm_req), .bm_op(bm_op), .bm_byte(bm_byte), .bm_ack(bm_ack),
        .bm_done(bm_done), .bm_nack(bm_nack), .bm_rdata(bm_rdata),
        .done(done), .status(status));

    int checks = 0, fails = 0;
    bit finished = 0;

    // operation log written by the byte-engine model
    logic [1:0] lop[256];
    logic [7:0] lbyte[256];
    logic lack[256];
    int nlog = 0, log_base = 0;
    int nack_idx = -1, slow_idx = -1, slow_d = 0;
    // expected list
    logic [1:0] eop[64];
    logic [7:0] ebyte[64];
    logic eack[64];
    int nexp = 0;
    // data streams
    logic [7:0] rxb[256];
    int nrx = 0, wcnt = 0;
    bit thr = 0;
    logic [2:0] got;

    assign wr_data = 8'h5A + wcnt[7:0];
    always @(posedge clk) if (wr_valid && wr_ready) wcnt <= wcnt + 1;
    always @(posedge clk) if (rd_valid && rd_ready) begin
        rxb[nrx[7:0]] <= rd_data;
        nrx <= nrx + 1;
    end

    initial forever begin
        @(negedge clk);
        rd_ready = thr ? ~rd_ready : 1'b1;
    end

    // byte-engine model: one request at a time, programmable delay/NACK
    initial begin
        bit busy = 0;
        int cnt = 0;
        bit nk = 0;
        logic [7:0] rb = 0;
        forever begin
            @(negedge clk);
            bm_done = 0;
            if (busy) begin
                if (cnt == 1) begin
                    bm_done = 1; bm_nack = nk; bm_rdata = rb; busy = 0;
                end else if (cnt > 1) cnt--;
            end
            if (bm_req) begin
                int rel;
                rel = nlog - log_base;
                lop[nlog[7:0]] = bm_op; lbyte[nlog[7:0]] = bm_byte; lack[nlog[7:0]] = bm_ack;
                nlog++;
                busy = 1;
                cnt = (rel == slow_idx) ? slow_d : 2;
                nk = (rel == nack_idx);
                rb = 8'hC3 ^ rel[7:0];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add(input logic [1:0] op, input logic [7:0] b, input logic a);
        eop[nexp] = op; ebyte[nexp] = b; eack[nexp] = a; nexp++;
    endtask

    function automatic logic [6:0] fold(input logic [6:0] d, input logic [31:0] a,
                                         input int n, input bit en);
        longint up;
        up = longint'(a) >> (8 * n);
        return (en && n > 0) ? (d | (7'(up) & 7'h07)) : d;
    endfunction

    // expected operation list of a complete transaction
    task automatic exp_full(input bit rd, input logic [6:0] d, input logic [31:0] a,
                            input int n, input int len, input int wb);
        nexp = 0;
        if (!rd || n > 0) add(2'd0, {d, 1'b0}, 0);
        for (int i = n - 1; i >= 0; i--) add(2'd1, 8'(a >> (8 * i)), 0);
        if (rd) add(2'd0, {d, 1'b1}, 0);
        for (int k = 0; k < len; k++)
            if (rd) add(2'd2, 8'h00, k < len - 1);
            else add(2'd1, 8'h5A + 8'(wb + k), 0);
        add(2'd3, 8'h00, 0);
    endtask

    task automatic chk_log(input string req);
        int n;
        bit ok;
        longint av, ev;
        n = nlog - log_base; ok = (n == nexp); av = n; ev = nexp;
        if (ok) for (int i = 0; i < nexp; i++) begin
            logic [7:0] j;
            bit m;
            j = 8'(log_base + i);
            m = (lop[j] == eop[i]) &&
                ((eop[i] > 2'd1) || lbyte[j] == ebyte[i]) &&
                ((eop[i] != 2'd2) || lack[j] == eack[i]);
            if (ok && !m) begin
                ok = 0; av = {i[7:0], 6'd0, lop[j], lbyte[j], 7'd0, lack[j]};
                ev = {i[7:0], 6'd0, eop[i], ebyte[i], 7'd0, eack[i]};
            end
        end
        chk(ok, req, "operation list", av, ev);
    endtask

    task automatic run(input bit rd, input bit pr, input bit fo, input logic [6:0] d,
                       input logic [31:0] a, input logic [2:0] n, input int len);
        log_base = nlog;
        @(negedge clk);
        cmd_read = rd; cmd_probe = pr; cmd_fold = fo; cmd_dev = d;
        cmd_addr = a; cmd_alen = n; cmd_len = LW'(len); cmd_valid = 1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        while (!done) @(negedge clk);
        got = status;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int wb, rs;
        string tg;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready && !bm_req && !done && !rd_valid, "R11", "reset state",
            {cmd_ready, bm_req, done, rd_valid}, 4'b1000);

        // sweep: direction x address length x byte count
        for (int rd = 0; rd < 2; rd++)
            for (int n = 0; n <= 4; n++)
                for (int len = 1; len <= 3; len++) begin
                    logic [31:0] a;
                    a = 32'h8A4C_21E7 ^ (n * 32'h0101_0101);
                    wb = wcnt; rs = nrx;
                    run(rd[0], 0, 0, 7'h50 + 7'(n), a, 3'(n), len);
                    tg = rd ? ((n > 0) ? "R2 R4 R12" : "R3 R4") : "R1 R12";
                    exp_full(rd[0], 7'h50 + 7'(n), a, n, len, wb);
                    chk_log(tg);
                    chk(got == 3'd0, tg, "status", got, 0);
                    if (rd) begin
                        bit ok;
                        int base;
                        ok = (nrx - rs == len);
                        base = (n > 0) ? n + 2 : 1;
                        for (int k = 0; k < len; k++)
                            if (rxb[8'(rs + k)] != (8'hC3 ^ 8'(base + k))) ok = 0;
                        chk(ok, "R2 R3", "read stream data", nrx - rs, len);
                    end
                end

        // R5: bad length / address length
        run(0, 0, 0, 7'h21, 32'h0, 3'd1, 0);
        chk(got == 3'd1 && nlog == log_base, "R5", "zero length", {got, 8'(nlog - log_base)}, 11'h100);
        run(1, 0, 0, 7'h21, 32'h0, 3'd5, 2);
        chk(got == 3'd1 && nlog == log_base, "R5", "alen 5", {got, 8'(nlog - log_base)}, 11'h100);

        // R11: done is one cycle and the block is ready again
        log_base = nlog;
        @(negedge clk);
        cmd_read = 0; cmd_probe = 0; cmd_alen = 0; cmd_len = 0; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done && cmd_ready, "R11", "done pulse width", {done, cmd_ready}, 2'b01);

        // R6: bus stays busy -> timeout; short busy -> proceeds
        bus_busy = 1;
        run(0, 0, 0, 7'h33, 32'h12, 3'd1, 1);
        chk(got == 3'd4 && nlog == log_base, "R6", "busy timeout", {got, 8'(nlog - log_base)}, 11'h400);
        fork begin repeat (10) @(negedge clk); bus_busy = 0; end join_none
        wb = wcnt;
        run(0, 0, 0, 7'h33, 32'h12, 3'd1, 1);
        exp_full(0, 7'h33, 32'h12, 1, 1, wb);
        chk_log("R6");
        chk(got == 3'd0, "R6", "status after short busy", got, 0);

        // R7: NACK on device byte of a read, and on an address byte of a write
        nack_idx = 0;
        run(1, 0, 0, 7'h44, 32'h0102, 3'd2, 2);
        nexp = 0; add(2'd0, {7'h44, 1'b0}, 0); add(2'd3, 0, 0);
        chk_log("R7");
        chk(got == 3'd2, "R7", "status device NACK", got, 2);
        nack_idx = 1;
        run(0, 0, 0, 7'h44, 32'hBEEF, 3'd2, 2);
        nexp = 0; add(2'd0, {7'h44, 1'b0}, 0); add(2'd1, 8'hBE, 0); add(2'd3, 0, 0);
        chk_log("R7");
        chk(got == 3'd2, "R7", "status address NACK", got, 2);
        nack_idx = -1;

        // R8: completion on the last cycle of the window, one cycle late, never
        slow_idx = 2; slow_d = BTMO; wb = wcnt;
        run(0, 0, 0, 7'h19, 32'h77, 3'd1, 2);
        exp_full(0, 7'h19, 32'h77, 1, 2, wb);
        chk_log("R8");
        chk(got == 3'd0, "R8", "status done at deadline", got, 0);
        slow_d = BTMO + 1; wb = wcnt;
        run(0, 0, 0, 7'h19, 32'h77, 3'd1, 2);
        nexp = 0; add(2'd0, {7'h19, 1'b0}, 0); add(2'd1, 8'h77, 0);
        add(2'd1, 8'h5A + 8'(wb), 0); add(2'd3, 0, 0);
        chk_log("R8");
        chk(got == 3'd4, "R8", "status one cycle late", got, 4);
        slow_d = 0; wb = wcnt;
        run(0, 0, 0, 7'h19, 32'h77, 3'd1, 2);
        nexp = 0; add(2'd0, {7'h19, 1'b0}, 0); add(2'd1, 8'h77, 0);
        add(2'd1, 8'h5A + 8'(wb), 0); add(2'd3, 0, 0);
        chk_log("R8");
        chk(got == 3'd4, "R8", "status hung byte", got, 4);
        slow_idx = -1;

        // R9: probe acknowledged and not acknowledged
        rs = nrx;
        run(0, 1, 1, 7'h2A, 32'hFFFF_FFFF, 3'd3, 9);
        nexp = 0; add(2'd0, {7'h2A, 1'b1}, 0); add(2'd2, 0, 0); add(2'd3, 0, 0);
        chk_log("R9");
        chk(got == 3'd0 && nrx == rs, "R9", "probe ack status/stream", {got, 8'(nrx - rs)}, 0);
        nack_idx = 0;
        run(0, 1, 0, 7'h2B, 32'h0, 3'd0, 1);
        nexp = 0; add(2'd0, {7'h2B, 1'b1}, 0); add(2'd3, 0, 0);
        chk_log("R9");
        chk(got == 3'd2, "R9", "probe nack status", got, 2);
        nack_idx = -1;

        // R10: folding of high address bits
        for (int c = 0; c < 4; c++) begin
            logic [31:0] a;
            int n;
            bit fo;
            a = (c < 2) ? 32'h0000_0B37 : 32'h0005_1234;
            n = (c < 2) ? 1 : 2;
            fo = (c != 1);
            wb = wcnt;
            run(0, 0, fo, 7'h50, a, 3'(n), 1);
            exp_full(0, fold(7'h50, a, n, fo), a, n, 1, wb);
            chk_log("R10");
        end

        // R13: consumer stalls on a read
        thr = 1; rs = nrx;
        run(1, 0, 0, 7'h61, 32'h9, 3'd1, 3);
        thr = 0;
        begin
            bit ok;
            ok = (nrx - rs == 3);
            for (int k = 0; k < 3; k++) if (rxb[8'(rs + k)] != (8'hC3 ^ 8'(3 + k))) ok = 0;
            chk(ok && got == 3'd0, "R13", "stalled read stream", nrx - rs, 3);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule